// File: doc/BRIEF.md
# Automated Program and Chip-Erase Status Engine

This block runs the embedded program and chip-erase operations of a small flash-like storage array. A command decoder sends it single-cycle start pulses. A program request carries a target address and data word. A chip-erase request carries nothing. Once an operation starts, the block sequences it over a number of clock cycles set by parameters and reports progress in two ways: the ready output, and a status word that replaces array data on reads.

Programming follows flash rules. It can only clear bits, so the stored word becomes the AND of the old word and the new data. If a request tries to raise a cleared bit, the operation never verifies. It runs into the time limit and parks in a timeout state, where it stays until the decoder delivers a Reset command. Chip erase first walks the array, forcing every word to zero. It then waits out the erase time and leaves every word at all ones. Reset logic can abort any operation at once.

Top module: `flash_op_engine`

## Requirements
- R1: After rst_n is released, ready_o is 1 and every word reads as all ones. A read in ready state puts the word at rd_addr_i on rd_data_o one cycle after rd_en_i.
- R2: A program request accepted while ready drops ready_o for exactly PROG_CYCLES cycles when no bit goes from 0 to 1. Afterwards the location reads back the true data written.
- R3: If a program request tries to set a 0 bit to 1, the target reads back as old AND new data. The operation enters the timeout state after TIME_LIMIT cycles, and ready_o stays 0.
- R4: A read while ready_o is 0 returns status instead of data. Bit 7 holds the complement of bit 7 of the program data, or 0 during chip erase. Bits 4 to 0 read 0.
- R5: Status bit 6 inverts between any two consecutive status reads, including in the timeout state.
- R6: Status bit 5 reads 1 in the timeout state and 0 during an operation that has not timed out.
- R7: The timeout state holds until reset_cmd_i, which returns the block to ready on the next cycle. reset_cmd_i while ready has no effect.
- R8: Program and erase requests that arrive while ready_o is 0 are ignored and change no word. When both requests arrive together while ready, program wins.
- R9: A chip erase keeps ready_o low for 2**AW + ERASE_CYCLES cycles. Afterwards every word reads all ones, whatever was programmed before.
- R10: abort_i returns ready_o to 1 on the next cycle from any state. An abort in the same cycle as a start request wins, and the request is dropped.
- R11: A read issued in the same cycle as the completing edge of an operation returns status. The next read returns array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prog_start_i | input | 1 | Program request pulse |
| prog_addr_i | input | AW | Program target address |
| prog_data_i | input | DW | Program data |
| erase_start_i | input | 1 | Chip-erase request pulse |
| reset_cmd_i | input | 1 | Reset command, leaves timeout state |
| abort_i | input | 1 | Immediate abort from reset logic |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | DW | Read data or status word |
| ready_o | output | 1 | 1 when no operation is running |

## Verification
A status read can land in the very cycle in which an operation completes. The bench provokes this by placing a read exactly PROG_CYCLES edges after the start. It expects status for that read, with bit 5 clear and the polling bit inverted, and real data from the read that follows. An abort can also coincide with a start request. This is driven in one cycle and judged by ready staying high and the target word staying all ones.

// File: rtl/fop_pkg.sv
package fop_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ZERO,
        ST_ERASE,
        ST_TMO
    } fop_state_e;
endpackage

// File: rtl/fop_array.sv
module fop_array #(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          fill_en,
    input  logic [AW-1:0] ra_addr,
    output logic [DW-1:0] ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [DW-1:0] rb_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    // Each word has its own register so that the erase fill can load all of them in one cycle
    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[w] <= '1;
            end else if (fill_en) begin
                mem_q[w] <= '1;
            end else if (wr_en && (wr_addr == AW'(w))) begin
                mem_q[w] <= wr_data;
            end
        end
    end

    assign ra_data = mem_q[ra_addr];
    assign rb_data = mem_q[rb_addr];
endmodule

// File: rtl/fop_ctrl.sv
module fop_ctrl
    import fop_pkg::*;
#(
    parameter int AW           = 4,
    parameter int DW           = 8,
    parameter int PROG_CYCLES  = 6,
    parameter int ERASE_CYCLES = 10,
    parameter int TIME_LIMIT   = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_start_i,
    input  logic [AW-1:0] prog_addr_i,
    input  logic [DW-1:0] prog_data_i,
    input  logic          erase_start_i,
    input  logic          reset_cmd_i,
    input  logic          abort_i,
    input  logic [DW-1:0] old_word_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    output logic          fill_en_o,
    output logic          busy_o,
    output logic          tmo_o,
    output logic          poll_o
);
    localparam int DEPTH  = 1 << AW;
    localparam int MAXCNT = (TIME_LIMIT > ERASE_CYCLES) ? TIME_LIMIT : ERASE_CYCLES;
    localparam int CW     = $clog2(MAXCNT + 1);

    typedef struct packed {
        fop_state_e    state;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic          conflict;
        logic          poll;
    } ctrl_s;

    ctrl_s r_q, r_d;

    always_comb begin
        r_d       = r_q;
        wr_en_o   = 1'b0;
        wr_addr_o = r_q.addr;
        wr_data_o = '0;
        fill_en_o = 1'b0;
        if (abort_i) begin
            r_d.state = ST_IDLE;
            r_d.cnt   = '0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (prog_start_i) begin
                        // Only 1 -> 0 transitions are possible: merge into the cell at once
                        wr_en_o      = 1'b1;
                        wr_addr_o    = prog_addr_i;
                        wr_data_o    = old_word_i & prog_data_i;
                        r_d.addr     = prog_addr_i;
                        r_d.conflict = |(prog_data_i & ~old_word_i);
                        r_d.poll     = ~prog_data_i[DW-1];
                        r_d.cnt      = '0;
                        r_d.state    = ST_PROG;
                    end else if (erase_start_i) begin
                        r_d.addr     = '0;
                        r_d.conflict = 1'b0;
                        r_d.poll     = 1'b0;
                        r_d.cnt      = '0;
                        r_d.state    = ST_ZERO;
                    end
                end
                ST_PROG: begin
                    if (!r_q.conflict && (r_q.cnt == CW'(PROG_CYCLES - 1))) begin
                        r_d.state = ST_IDLE;
                    end else if (r_q.conflict && (r_q.cnt == CW'(TIME_LIMIT - 1))) begin
                        r_d.state = ST_TMO;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_ZERO: begin
                    // Pre-program pass: every word forced to zero before erasing
                    wr_en_o   = 1'b1;
                    wr_addr_o = r_q.addr;
                    wr_data_o = '0;
                    if (r_q.addr == AW'(DEPTH - 1)) begin
                        r_d.state = ST_ERASE;
                        r_d.cnt   = '0;
                    end else begin
                        r_d.addr = r_q.addr + 1'b1;
                    end
                end
                ST_ERASE: begin
                    if (r_q.cnt == CW'(ERASE_CYCLES - 1)) begin
                        fill_en_o = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                ST_TMO: begin
                    if (reset_cmd_i) begin
                        r_d.state = ST_IDLE;
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, cnt: '0, addr: '0, conflict: 1'b0, poll: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = (r_q.state != ST_IDLE);
    assign tmo_o  = (r_q.state == ST_TMO);
    assign poll_o = r_q.poll;
endmodule

// File: rtl/fop_status.sv
module fop_status #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en_i,
    input  logic          busy_i,
    input  logic          tmo_i,
    input  logic          poll_i,
    input  logic [DW-1:0] arr_word_i,
    output logic [DW-1:0] rd_data_o
);
    localparam int POLL_BIT = DW - 1;
    localparam int TOG_BIT  = DW - 2;
    localparam int TMO_BIT  = DW - 3;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          tog;
    } stat_s;

    stat_s s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (rd_en_i) begin
            if (busy_i) begin
                s_d.data           = '0;
                s_d.data[POLL_BIT] = poll_i;
                s_d.data[TOG_BIT]  = s_q.tog;
                s_d.data[TMO_BIT]  = tmo_i;
                s_d.tog            = ~s_q.tog;
            end else begin
                s_d.data = arr_word_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{data: '0, tog: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data_o = s_q.data;
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine #(
    parameter int AW           = 4,
    parameter int DW           = 8,
    parameter int PROG_CYCLES  = 6,
    parameter int ERASE_CYCLES = 10,
    parameter int TIME_LIMIT   = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_start_i,
    input  logic [AW-1:0] prog_addr_i,
    input  logic [DW-1:0] prog_data_i,
    input  logic          erase_start_i,
    input  logic          reset_cmd_i,
    input  logic          abort_i,
    input  logic          rd_en_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [DW-1:0] rd_data_o,
    output logic          ready_o
);
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          fill_en;
    logic [DW-1:0] rd_word;
    logic [DW-1:0] old_word;
    logic          busy;
    logic          tmo;
    logic          poll;

    fop_array #(.AW(AW), .DW(DW)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .fill_en (fill_en),
        .ra_addr (rd_addr_i),
        .ra_data (rd_word),
        .rb_addr (prog_addr_i),
        .rb_data (old_word)
    );

    fop_ctrl #(
        .AW(AW), .DW(DW), .PROG_CYCLES(PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES), .TIME_LIMIT(TIME_LIMIT)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .prog_start_i  (prog_start_i),
        .prog_addr_i   (prog_addr_i),
        .prog_data_i   (prog_data_i),
        .erase_start_i (erase_start_i),
        .reset_cmd_i   (reset_cmd_i),
        .abort_i       (abort_i),
        .old_word_i    (old_word),
        .wr_en_o       (wr_en),
        .wr_addr_o     (wr_addr),
        .wr_data_o     (wr_data),
        .fill_en_o     (fill_en),
        .busy_o        (busy),
        .tmo_o         (tmo),
        .poll_o        (poll)
    );

    fop_status #(.DW(DW)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (rd_en_i),
        .busy_i     (busy),
        .tmo_i      (tmo),
        .poll_i     (poll),
        .arr_word_i (rd_word),
        .rd_data_o  (rd_data_o)
    );

    assign ready_o = ~busy;
endmodule

// File: rtl/fop_checker.sv
module fop_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prog_start_i,
    input logic          erase_start_i,
    input logic          reset_cmd_i,
    input logic          abort_i,
    input logic          rd_en_i,
    input logic [DW-1:0] rd_data_o,
    input logic          ready_o,
    input logic          tmo
);
    // R2: an accepted start request takes the block out of ready
    a_r2_start_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && (prog_start_i || erase_start_i) && !abort_i) |=> !ready_o);

    // R10: abort always returns to ready
    a_r10_abort_ready: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> ready_o);

    // R7: timeout is held until a Reset command or abort
    a_r7_timeout_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && !reset_cmd_i && !abort_i) |=> tmo);

    // R7: a Reset command leaves timeout
    a_r7_reset_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && reset_cmd_i) |=> ready_o);

    // R6: status read in timeout shows bit 5 set
    a_r6_flag_in_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && tmo) |=> rd_data_o[DW-3]);

    // R4: low status bits are zero
    a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !ready_o) |=> (rd_data_o[DW-4:0] == '0));

    // R5: consecutive status reads invert bit 6
    a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !ready_o && $past(rd_en_i && !ready_o))
        |=> (rd_data_o[DW-2] != $past(rd_data_o[DW-2])));
endmodule

bind flash_op_engine fop_checker #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .prog_start_i  (prog_start_i),
    .erase_start_i (erase_start_i),
    .reset_cmd_i   (reset_cmd_i),
    .abort_i       (abort_i),
    .rd_en_i       (rd_en_i),
    .rd_data_o     (rd_data_o),
    .ready_o       (ready_o),
    .tmo           (tmo)
);

// File: tb/sim_flash_op_engine.sv
module sim_flash_op_engine;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int PC = 6;
    localparam int EC = 10;
    localparam int TL = 20;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_start_i = 1'b0;
    logic [AW-1:0] prog_addr_i = '0;
    logic [DW-1:0] prog_data_i = '0;
    logic          erase_start_i = 1'b0;
    logic          reset_cmd_i = 1'b0;
    logic          abort_i = 1'b0;
    logic          rd_en_i = 1'b0;
    logic [AW-1:0] rd_addr_i = '0;
    logic [DW-1:0] rd_data_o;
    logic          ready_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    flash_op_engine #(
        .AW(AW), .DW(DW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC), .TIME_LIMIT(TL)
    ) u0 (.*);

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        rd_en_i   = 1'b1;
        rd_addr_i = a;
        @(posedge clk);
        #1;
        v       = rd_data_o;
        rd_en_i = 1'b0;
    endtask

    task automatic start_prog(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        prog_start_i = 1'b1;
        prog_addr_i  = a;
        prog_data_i  = d;
        @(posedge clk);
        #1;
        prog_start_i = 1'b0;
    endtask

    task automatic start_erase();
        @(negedge clk);
        erase_start_i = 1'b1;
        @(posedge clk);
        #1;
        erase_start_i = 1'b0;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (!ready_o && n < 1000) begin
            @(posedge clk);
            #1;
            n++;
        end
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        check("R1 ready after reset", int'(ready_o), 1);
        rd(3, v);
        check("R1 erased word", int'(v), 'hFF);
    endtask

    task automatic t_program();
        logic [DW-1:0] v;
        int n;
        start_prog(2, 8'hA5);
        check("R2 busy after start", int'(ready_o), 0);
        wait_ready(n);
        check("R2 program duration", n, PC);
        rd(2, v);
        check("R2 true data", int'(v), 'hA5);
    endtask

    task automatic t_status();
        logic [DW-1:0] a, b;
        int n;
        start_prog(7, 8'h3C);
        rd(0, a);
        rd(0, b);
        check("R4 poll bit", int'(a[7]), 1);
        check("R4 low bits", int'(a[4:0]), 0);
        check("R6 no timeout flag", int'(a[5]), 0);
        check("R5 toggle", int'(a[6] ^ b[6]), 1);
        wait_ready(n);
        rd(7, a);
        check("R2 data 3C", int'(a), 'h3C);
    endtask

    task automatic t_timeout();
        logic [DW-1:0] a, b;
        int n;
        start_prog(2, 8'h5A);
        repeat (TL + 2) @(posedge clk);
        #1;
        check("R3 stays busy", int'(ready_o), 0);
        rd(0, a);
        rd(0, b);
        check("R6 timeout flag", int'(a[5]), 1);
        check("R4 poll in timeout", int'(a[7]), 1);
        check("R5 toggle in timeout", int'(a[6] ^ b[6]), 1);
        start_prog(5, 8'h00);
        check("R7 still timeout", int'(ready_o), 0);
        @(negedge clk);
        reset_cmd_i = 1'b1;
        @(posedge clk);
        #1;
        reset_cmd_i = 1'b0;
        check("R7 reset cmd exits", int'(ready_o), 1);
        rd(5, a);
        check("R8 ignored in timeout", int'(a), 'hFF);
        rd(2, a);
        check("R3 bits stay 0", int'(a), 'h00);
        @(negedge clk);
        reset_cmd_i = 1'b1;
        @(posedge clk);
        #1;
        reset_cmd_i = 1'b0;
        check("R7 idle reset no effect", int'(ready_o), 1);
        rd(2, a);
        check("R7 idle reset keeps data", int'(a), 'h00);
        n = 0;
    endtask

    task automatic t_ignore();
        logic [DW-1:0] v;
        int n;
        start_prog(9, 8'hF0);
        start_prog(10, 8'h00);
        @(negedge clk);
        erase_start_i = 1'b1;
        @(posedge clk);
        #1;
        erase_start_i = 1'b0;
        wait_ready(n);
        rd(10, v);
        check("R8 busy start ignored", int'(v), 'hFF);
        rd(9, v);
        check("R8 busy erase ignored", int'(v), 'hF0);
        @(negedge clk);
        prog_start_i = 1'b1;
        erase_start_i = 1'b1;
        prog_addr_i = 11;
        prog_data_i = 8'h81;
        @(posedge clk);
        #1;
        prog_start_i = 1'b0;
        erase_start_i = 1'b0;
        wait_ready(n);
        check("R8 program wins duration", n, PC);
        rd(11, v);
        check("R8 program wins data", int'(v), 'h81);
    endtask

    task automatic t_edge();
        logic [DW-1:0] v;
        start_prog(12, 8'h77);
        repeat (PC - 1) @(posedge clk);
        rd(12, v);
        check("R11 status at completion", int'(v[5]), 0);
        check("R11 poll at completion", int'(v[7]), 1);
        check("R11 ready after", int'(ready_o), 1);
        rd(12, v);
        check("R11 data next read", int'(v), 'h77);
    endtask

    task automatic t_erase();
        logic [DW-1:0] v;
        int n;
        start_erase();
        rd(0, v);
        check("R4 erase poll bit", int'(v[7]), 0);
        check("R6 erase no flag", int'(v[5]), 0);
        wait_ready(n);
        start_erase();
        wait_ready(n);
        check("R9 erase duration", n, DEPTH + EC);
        for (int i = 0; i < DEPTH; i++) begin
            rd(AW'(i), v);
            check("R9 all ones", int'(v), 'hFF);
        end
    endtask

    task automatic t_abort();
        logic [DW-1:0] v;
        start_prog(4, 8'h00);
        @(negedge clk);
        abort_i = 1'b1;
        @(posedge clk);
        #1;
        abort_i = 1'b0;
        check("R10 abort ready", int'(ready_o), 1);
        @(negedge clk);
        abort_i = 1'b1;
        prog_start_i = 1'b1;
        prog_addr_i = 6;
        prog_data_i = 8'h00;
        @(posedge clk);
        #1;
        abort_i = 1'b0;
        prog_start_i = 1'b0;
        check("R10 abort beats start", int'(ready_o), 1);
        rd(6, v);
        check("R10 start dropped", int'(v), 'hFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_program();
        t_status();
        t_timeout();
        t_ignore();
        t_edge();
        t_erase();
        t_abort();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule